// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the byte address sequence for one two-dimensional DMA work unit. A work unit is a set of rows. Each row holds a fixed number of items, and each item is one transfer. A channel controller programs a base address, a row length, a signed step between items of a row, a row count, a signed step taken at the end of each row, and the transfer word size. It then pulses `start`. After that, each `xfer_done` pulse moves the address to the next item. At the end of a row the row step replaces the item step. After the last item no step is taken, so the address stays on the last item. Signed steps let the generator walk interleaved data, for example splitting an R,G,B stream into three planes.

The block has two modes. In one-shot mode it raises `done` after the last item and ignores further transfers until the next start. In reload mode it returns to its programmed state after the last item and begins the next work unit at once. An interrupt line follows either every row end or only the work-unit end, as selected at start. The settings are checked when `start` is sampled. A bad setting raises `cfg_err` and no work unit begins.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset `addr` is 0 and `busy`, `done`, `cfg_err`, `row_end`, `unit_end` and `irq` are all 0.
- R2: When `start` is sampled with a valid setting, on the next cycle `addr` equals `cfg_base`, `busy` is 1, and `done` and `cfg_err` are 0. The setting is captured at that point, and later changes on the `cfg_*` inputs have no effect until the next start.
- R3: A setting is invalid when any of the following holds: `cfg_row_len` is below 2, `cfg_rows` is 0, or `cfg_base`, `cfg_item_step` or `cfg_row_step` is not a multiple of the word size. The word size encodes 0=1, 1=2, 2=4 and 3=8 bytes. An invalid start sets `cfg_err` to 1 and leaves `busy` at 0 on the next cycle.
- R4: On an `xfer_done` that is not the last item of its row, the next cycle shows `addr` plus `cfg_item_step`. The step is 16-bit signed and sign-extended, and the sum wraps modulo 2^32.
- R5: On the `xfer_done` for the last item of a row that is not the last row, the next cycle shows `addr` plus `cfg_row_step` (signed), and `row_end` is high for exactly one cycle.
- R6: On the `xfer_done` for the last item of the last row, no step is applied, and `row_end` and `unit_end` are both high for one cycle. In one-shot mode `addr` keeps the last item's address, `busy` drops to 0 and `done` rises to 1.
- R7: In reload mode (`cfg_reload`=1), the last item instead returns `addr` to the captured base and restores both counts. `busy` stays 1 and `done` stays 0.
- R8: With `cfg_irq_row`=1, `irq` pulses together with every `row_end`. With `cfg_irq_row`=0, `irq` pulses only together with `unit_end`.
- R9: `xfer_done` has no effect while `busy` is 0, which includes the time after a one-shot work unit is done. `start` takes priority over `xfer_done` in the same cycle.
- R10: With 3 items per row, an item step of 4 elements, 4 rows and a row step of 1-2*4 elements, the addresses follow the de-interleave order 0,4,8,1,5,9,... elements from the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a work unit with the current setting |
| cfg_base | input | 32 | Base byte address |
| cfg_row_len | input | 16 | Items per row (at least 2) |
| cfg_item_step | input | 16 | Signed byte step between items of a row |
| cfg_rows | input | 16 | Number of rows (at least 1) |
| cfg_row_step | input | 16 | Signed byte step applied at the end of a row |
| cfg_wsize | input | 2 | Word size: 0=1, 1=2, 2=4, 3=8 bytes |
| cfg_reload | input | 1 | 1 = reload mode, 0 = one-shot mode |
| cfg_irq_row | input | 1 | 1 = interrupt on each row end, 0 = on unit end only |
| xfer_done | input | 1 | One transfer has completed |
| addr | output | 32 | Byte address of the current item |
| busy | output | 1 | A work unit is active |
| done | output | 1 | A one-shot work unit has finished |
| cfg_err | output | 1 | The last start had an invalid setting |
| row_end | output | 1 | One-cycle pulse at the end of a row |
| unit_end | output | 1 | One-cycle pulse at the end of a work unit |
| irq | output | 1 | Interrupt pulse, per the mode selected at start |

## Verification
A wrong item or row count inside the block shows up as a step of the wrong kind. The generator takes a row step where it should take an item step, or the reverse. This appears on `addr` and `row_end` in the cycle after the `xfer_done` that exposes it, so it usually shows within one row. A wrong captured step or base gives a wrong address on the first transfer that uses it, or on the first reload. A stuck busy or done state shows as address movement, or the lack of it, after the next `xfer_done`. The bench keeps a model written with integers and compares every output on every cycle. It also checks the de-interleave order against a list of addresses worked out separately.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [1:0] {
        STEP_ITEM = 2'd0,
        STEP_ROW  = 2'd1,
        STEP_NONE = 2'd2
    } step_sel_e;

    // Low-bit mask that must be clear for a value aligned to the word size.
    function automatic logic [2:0] align_mask(input logic [1:0] wsize);
        case (wsize)
            2'd0:    align_mask = 3'b000;
            2'd1:    align_mask = 3'b001;
            2'd2:    align_mask = 3'b011;
            default: align_mask = 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/dma2d_cfg_check.sv
module dma2d_cfg_check #(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [STEP_W-1:0] item_step,
    input  logic [STEP_W-1:0] row_step,
    input  logic [CNT_W-1:0]  row_len,
    input  logic [CNT_W-1:0]  rows,
    input  logic [1:0]        wsize,
    output logic              bad
);
    localparam int LOWB = 3;

    logic [LOWB-1:0] mask;
    logic            misaligned;
    logic            bad_count;

    always_comb begin
        mask       = dma2d_pkg::align_mask(wsize);
        misaligned = |(base[LOWB-1:0] & mask)
                   | |(item_step[LOWB-1:0] & mask)
                   | |(row_step[LOWB-1:0] & mask);
        bad_count  = (row_len < CNT_W'(2)) | (rows == '0);
        bad        = misaligned | bad_count;
    end

    // R3: a one-item row can never be accepted
    always_comb begin
        if (row_len == CNT_W'(1)) begin
            a_r3_short_row: assert (bad);
        end
    end
endmodule

// File: rtl/dma2d_step_add.sv
module dma2d_step_add #(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16
) (
    input  logic [ADDR_W-1:0]     addr_cur,
    input  logic [STEP_W-1:0]     item_step,
    input  logic [STEP_W-1:0]     row_step,
    input  dma2d_pkg::step_sel_e  sel,
    output logic [ADDR_W-1:0]     addr_nxt
);
    logic [STEP_W-1:0] step_raw;
    logic [ADDR_W-1:0] step_ext;

    always_comb begin
        case (sel)
            dma2d_pkg::STEP_ITEM: step_raw = item_step;
            dma2d_pkg::STEP_ROW:  step_raw = row_step;
            default:              step_raw = '0;
        endcase
        step_ext = ADDR_W'($signed(step_raw));
        addr_nxt = addr_cur + step_ext;
    end

    // R6: the final step never moves the address
    always_comb begin
        if (sel == dma2d_pkg::STEP_NONE) begin
            a_r6_hold_addr: assert (addr_nxt == addr_cur);
        end
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_row_len,
    input  logic [STEP_W-1:0] cfg_item_step,
    input  logic [CNT_W-1:0]  cfg_rows,
    input  logic [STEP_W-1:0] cfg_row_step,
    input  logic [1:0]        cfg_wsize,
    input  logic              cfg_reload,
    input  logic              cfg_irq_row,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic              row_end,
    output logic              unit_end,
    output logic              irq
);
    import dma2d_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [STEP_W-1:0] istep;
        logic [STEP_W-1:0] rstep;
        logic [CNT_W-1:0]  rlen;
        logic [CNT_W-1:0]  rows;
        logic              reload;
        logic              irq_row;
    } cfg_t;

    typedef struct packed {
        cfg_t              cfg;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  icnt;
        logic [CNT_W-1:0]  rcnt;
        logic              busy;
        logic              done;
        logic              err;
        logic              row_end;
        logic              unit_end;
        logic              irq;
    } state_t;

    state_t            st_d, st_q;
    step_sel_e         sel;
    logic [ADDR_W-1:0] addr_stepped;
    logic              cfg_bad;

    dma2d_cfg_check #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) i_check (
        .base      (cfg_base),
        .item_step (cfg_item_step),
        .row_step  (cfg_row_step),
        .row_len   (cfg_row_len),
        .rows      (cfg_rows),
        .wsize     (cfg_wsize),
        .bad       (cfg_bad)
    );

    always_comb begin
        if (st_q.icnt != CNT_ONE)      sel = STEP_ITEM;
        else if (st_q.rcnt != CNT_ONE) sel = STEP_ROW;
        else                           sel = STEP_NONE;
    end

    dma2d_step_add #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) i_add (
        .addr_cur  (st_q.addr),
        .item_step (st_q.cfg.istep),
        .row_step  (st_q.cfg.rstep),
        .sel       (sel),
        .addr_nxt  (addr_stepped)
    );

    always_comb begin
        st_d          = st_q;
        st_d.row_end  = 1'b0;
        st_d.unit_end = 1'b0;
        st_d.irq      = 1'b0;
        if (start) begin
            st_d.done = 1'b0;
            if (cfg_bad) begin
                st_d.err  = 1'b1;
                st_d.busy = 1'b0;
            end else begin
                st_d.err         = 1'b0;
                st_d.busy        = 1'b1;
                st_d.cfg.base    = cfg_base;
                st_d.cfg.istep   = cfg_item_step;
                st_d.cfg.rstep   = cfg_row_step;
                st_d.cfg.rlen    = cfg_row_len;
                st_d.cfg.rows    = cfg_rows;
                st_d.cfg.reload  = cfg_reload;
                st_d.cfg.irq_row = cfg_irq_row;
                st_d.addr        = cfg_base;
                st_d.icnt        = cfg_row_len;
                st_d.rcnt        = cfg_rows;
            end
        end else if (st_q.busy && xfer_done) begin
            st_d.addr = addr_stepped;
            case (sel)
                STEP_ITEM: begin
                    st_d.icnt = st_q.icnt - CNT_ONE;
                end
                STEP_ROW: begin
                    st_d.icnt    = st_q.cfg.rlen;
                    st_d.rcnt    = st_q.rcnt - CNT_ONE;
                    st_d.row_end = 1'b1;
                    st_d.irq     = st_q.cfg.irq_row;
                end
                default: begin
                    st_d.row_end  = 1'b1;
                    st_d.unit_end = 1'b1;
                    st_d.irq      = 1'b1;
                    if (st_q.cfg.reload) begin
                        st_d.addr = st_q.cfg.base;
                        st_d.icnt = st_q.cfg.rlen;
                        st_d.rcnt = st_q.cfg.rows;
                    end else begin
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr     = st_q.addr;
    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign cfg_err  = st_q.err;
    assign row_end  = st_q.row_end;
    assign unit_end = st_q.unit_end;
    assign irq      = st_q.irq;

    a_r4_item_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_done && !start && st_q.icnt != CNT_ONE)
        |=> (addr == $past(addr) + ADDR_W'($signed($past(st_q.cfg.istep)))));

    a_r6_unit_end_row_end: assert property (@(posedge clk) disable iff (!rst_n)
        unit_end |-> row_end);

    a_r3_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy);

    a_r9_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(addr) && !busy && !row_end));

    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> row_end);

    a_r6_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));
endmodule

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [15:0] cfg_row_len = '0;
    logic [15:0] cfg_item_step = '0;
    logic [15:0] cfg_rows = '0;
    logic [15:0] cfg_row_step = '0;
    logic [1:0]  cfg_wsize = '0;
    logic        cfg_reload = 1'b0;
    logic        cfg_irq_row = 1'b0;
    logic        xfer_done = 1'b0;
    logic [31:0] addr;
    logic        busy, done, cfg_err, row_end, unit_end, irq;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // behavioural reference state
    logic [31:0] m_addr, m_base;
    int          m_i, m_r, m_len, m_rows, m_istep, m_rstep;
    bit          m_busy, m_done, m_err, m_re, m_ue, m_irq, m_reload, m_irqrow;
    string       m_tag = "R1";

    always #5 clk = ~clk;

    dma2d_addr_gen i_dma2d_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_row_len(cfg_row_len), .cfg_item_step(cfg_item_step),
        .cfg_rows(cfg_rows), .cfg_row_step(cfg_row_step), .cfg_wsize(cfg_wsize),
        .cfg_reload(cfg_reload), .cfg_irq_row(cfg_irq_row), .xfer_done(xfer_done),
        .addr(addr), .busy(busy), .done(done), .cfg_err(cfg_err),
        .row_end(row_end), .unit_end(unit_end), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_addr = 0; m_busy = 0; m_done = 0; m_err = 0;
            m_re = 0; m_ue = 0; m_irq = 0; m_tag = "R1";
        end else begin
            m_re = 0; m_ue = 0; m_irq = 0;
            if (start) begin
                int sz;
                bit bad;
                sz  = 1 << cfg_wsize;
                bad = (cfg_row_len < 2) || (cfg_rows == 0) || (cfg_base % sz != 0)
                   || ($signed(cfg_item_step) % sz != 0) || ($signed(cfg_row_step) % sz != 0);
                m_done = 0;
                if (bad) begin
                    m_err = 1; m_busy = 0; m_tag = "R3";
                end else begin
                    m_err = 0; m_busy = 1; m_tag = "R2";
                    m_base = cfg_base; m_addr = cfg_base;
                    m_len = cfg_row_len; m_rows = cfg_rows;
                    m_i = m_len; m_r = m_rows;
                    m_istep = $signed(cfg_item_step); m_rstep = $signed(cfg_row_step);
                    m_reload = cfg_reload; m_irqrow = cfg_irq_row;
                end
            end else if (m_busy && xfer_done) begin
                if (m_i > 1) begin
                    m_i--; m_addr = m_addr + 32'(m_istep); m_tag = "R4";
                end else if (m_r > 1) begin
                    m_r--; m_i = m_len; m_addr = m_addr + 32'(m_rstep);
                    m_re = 1; m_irq = m_irqrow; m_tag = "R5";
                end else begin
                    m_re = 1; m_ue = 1; m_irq = 1;
                    if (m_reload) begin
                        m_addr = m_base; m_i = m_len; m_r = m_rows; m_tag = "R7";
                    end else begin
                        m_busy = 0; m_done = 1; m_tag = "R6";
                    end
                end
            end else if (xfer_done) begin
                m_tag = "R9";
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        vectors++;
        if (addr !== m_addr || busy !== m_busy || done !== m_done || cfg_err !== m_err
            || row_end !== m_re || unit_end !== m_ue) begin
            errors++;
            $display("FAIL %s: addr=%h busy=%b done=%b err=%b re=%b ue=%b expected addr=%h busy=%b done=%b err=%b re=%b ue=%b",
                     m_tag, addr, busy, done, cfg_err, row_end, unit_end,
                     m_addr, m_busy, m_done, m_err, m_re, m_ue);
        end
        vectors++;
        if (irq !== m_irq) begin
            errors++;
            $display("FAIL R8: irq=%b expected %b", irq, m_irq);
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected end by 100000 cycles");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] b, input int len, input int istep,
                         input int rows, input int rstep, input int ws,
                         input bit rel, input bit irow);
        cfg_base = b; cfg_row_len = 16'(len); cfg_item_step = 16'(istep);
        cfg_rows = 16'(rows); cfg_row_step = 16'(rstep); cfg_wsize = 2'(ws);
        cfg_reload = rel; cfg_irq_row = irow;
        start = 1'b1; tick(1); start = 1'b0; tick(1);
    endtask

    task automatic xfers(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            xfer_done = 1'b1; tick(1); xfer_done = 1'b0; tick(gap);
        end
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R3: invalid settings
        setup(32'h1000, 1, 4, 4, 4, 2, 0, 0);
        setup(32'h1002, 3, 4, 4, 4, 2, 0, 0);
        setup(32'h1000, 3, 4, 4, -6, 2, 0, 0);
        setup(32'h1000, 3, 4, 0, 4, 2, 0, 0);
        setup(32'h1001, 2, 3, 2, -5, 0, 0, 0);  // byte size: accepted
        xfers(4, 0);

        // R10: RGB de-interleave, 4-byte words, irq per row
        setup(32'h2000, 3, 16, 4, -28, 2, 0, 1);
        for (int k = 0; k < 12; k++) begin
            logic [31:0] exp_a;
            exp_a = 32'h2000 + 32'(4 * ((k % 3) * 4 + k / 3));
            vectors++;
            if (addr !== exp_a) begin
                errors++;
                $display("FAIL R10: item %0d addr=%h expected %h", k, addr, exp_a);
            end
            xfer_done = 1'b1; tick(1); xfer_done = 1'b0; tick(k % 2);
        end
        // R9: ignored after one-shot done, R2: config change has no effect
        cfg_item_step = 16'h0100;
        xfers(3, 1);
        tick(2);

        // R7 R8: reload mode with negative steps, irq on unit end only
        setup(32'h8000, 2, -8, 3, -24, 3, 1, 0);
        xfers(14, 0);
        // R9: start wins over xfer_done
        cfg_base = 32'h4000; start = 1'b1; xfer_done = 1'b1; tick(1);
        start = 1'b0; xfer_done = 1'b0; tick(1);
        xfers(3, 1);

        // R4: wrap modulo 2^32
        setup(32'hFFFF_FFF0, 4, 8, 2, 8, 3, 0, 1);
        xfers(8, 0);
        tick(3);

        // R1: reset in mid run
        setup(32'h100, 3, 2, 3, 2, 1, 1, 1);
        xfers(2, 0);
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule